// File: doc/BRIEF.md
# L1 Data Cache Tag Directory

This block holds the tag, coherency state, lock flag and tag parity of every line of a 32-Kbyte, eight-way set-associative level-1 data cache with 32-byte lines. The cache has 128 sets. A controller sends one operation per cycle on a single port. A lookup returns hit or miss, the hitting way, its coherency state and a replacement candidate. A fill writes a way. Line commands invalidate, lock or unlock the line that matches an address. The data array, bus traffic, snooping and refill sequencing live in that controller.

Replacement uses a binary-tree pseudo-LRU with seven bits per set. The tree walk steers around locked lines, and an empty way is always taken before the tree's choice. A one-shot flush control clears the whole directory one set per cycle while the operation port is held off. Tag parity is written and checked only while the parity enable input is high.

Top module: `l1_tag_dir`

## Requirements
- R1: With the default geometry, address bits [4:0] are the line offset, bits [11:5] select one of 128 sets and bits [31:12] form the 20-bit tag. A tag present in one set misses in any other set.
- R2: An operation is accepted in a cycle where `op_valid` and `op_ready` are both high. A lookup (op code 0) raises `rsp_valid` in the next cycle only. Fill (1), invalidate (2), lock (3) and unlock (4) produce no response.
- R3: States are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3. A fill writes `op_state` into way `op_way` of the addressed set and clears its lock. A lookup hit reports that way on `rsp_way` and its state on `rsp_state`. A miss reports way 0 and state 0.
- R4: When the addressed set holds an Invalid way, the victim is the lowest-numbered Invalid way.
- R5: Each set keeps seven tree bits. Node n has children 2n+1 and 2n+2, and a bit of 0 sends the victim toward the lower-numbered half. Every lookup hit and every fill sets the bits on the accessed way's path to point away from it. Misses and line commands leave the tree unchanged. The victim reported is taken from the tree as it was before the operation.
- R6: A valid locked way is never reported as victim. If the subtree a tree bit selects holds no eligible way, the walk takes the other subtree.
- R7: When all eight ways of the set are valid and locked, `rsp_noalloc` is 1 and `rsp_victim` is 0.
- R8: A lock or unlock command sets or clears the lock of the way whose tag hits. A locked line still hits. A command whose tag misses changes nothing.
- R9: An invalidate command that hits sets the line to Invalid and clears its lock, so later lookups of that tag miss.
- R10: A fill stores the XOR of the tag bits as parity when `par_en` is 1, and 0 otherwise. While `par_en` is 1, a tag match whose stored parity disagrees sets `rsp_perr` and reports a miss. While `par_en` is 0, parity is ignored.
- R11: A one-cycle pulse on `flush_go` raises `flush_busy` for exactly 128 cycles. During that time it clears the state and lock of one set per cycle, holds `op_ready` low and drops every operation offered. `flush_busy` then returns to 0 by itself.
- R12: After reset every line is Invalid and unlocked, every tree is 0, `flush_busy` and `rsp_valid` are 0, and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_en | input | 1 | Enables parity generation on fills and checking on matches |
| flush_go | input | 1 | Pulse that starts a whole-directory invalidate |
| flush_busy | output | 1 | Flush in progress; clears itself when done |
| op_ready | output | 1 | Port can accept an operation |
| op_valid | input | 1 | Operation offered |
| op_code | input | 3 | 0 lookup, 1 fill, 2 invalidate, 3 lock, 4 unlock |
| op_addr | input | 32 | Byte address of the line |
| op_way | input | 3 | Way written by a fill |
| op_state | input | 2 | Coherency state written by a fill |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 3 | Hitting way |
| rsp_state | output | 2 | State of the hitting line |
| rsp_perr | output | 1 | Parity mismatch on a matching tag |
| rsp_victim | output | 3 | Replacement way for this set |
| rsp_vic_state | output | 2 | Current state of the victim way |
| rsp_noalloc | output | 1 | Every way locked; do not allocate |

## Verification
The embedded properties check, on every response, several invariants. A reported victim is never a valid locked line. A no-allocate answer only appears when the whole set is locked. A parity error never comes with a hit, and a hit never reports Invalid. They also check that no response follows a cycle in which the flush is running, and that the flush ends only after visiting the last set. Which way the tree picks after a given history of hits and fills, the invalid-way priority, the effect of line commands and of the parity enable, and the exact length of the flush depend on sequences. Only the bench's scenarios show these.

// File: rtl/l1td_pkg.sv
package l1td_pkg;
   typedef enum logic [1:0] {
      ST_INV = 2'd0,
      ST_SHR = 2'd1,
      ST_EXC = 2'd2,
      ST_MOD = 2'd3
   } mesi_e;

   typedef enum logic [2:0] {
      OP_LOOK   = 3'd0,
      OP_FILL   = 3'd1,
      OP_INV    = 3'd2,
      OP_LOCK   = 3'd3,
      OP_UNLOCK = 3'd4
   } dir_op_e;
endpackage

// File: rtl/l1td_match.sv
module l1td_match #(
   parameter int WAYS  = 8,
   parameter int TAG_W = 20
) (
   input  logic [TAG_W-1:0]            tag_in,
   input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic [WAYS-1:0]             way_valid,
   input  logic [WAYS-1:0]             way_par,
   input  logic                        par_en,
   output logic                        hit,
   output logic [$clog2(WAYS)-1:0]     hit_way,
   output logic                        perr
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0] good_v;
   logic [WAYS-1:0] bad_v;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      logic same;
      assign same     = way_valid[w] && (way_tag[w] == tag_in);
      assign bad_v[w]  = same && par_en && (way_par[w] != (^tag_in));
      assign good_v[w] = same && !bad_v[w];
   end

   assign perr = |bad_v;
   assign hit  = (|good_v) && !perr;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (good_v[w]) hit_way = w[WAY_W-1:0];
   end
endmodule

// File: rtl/l1td_victim.sv
module l1td_victim #(
   parameter int WAYS = 8
) (
   input  logic [WAYS-1:0]          valid,
   input  logic [WAYS-1:0]          locked,
   input  logic [WAYS-2:0]          tree,
   output logic [$clog2(WAYS)-1:0]  victim,
   output logic                     noalloc
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0] elig;
   logic [WAYS-2:0] tsh;
   logic [WAY_W-1:0] pick;
   logic found, d, any;
   int   p;

   assign elig    = ~(valid & locked);
   assign noalloc = ~|elig;

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!valid[w]) begin
            found = 1'b1;
            pick  = w[WAY_W-1:0];
         end
      p   = 0;
      d   = 1'b0;
      any = 1'b0;
      tsh = '0;
      for (int l = 0; l < WAY_W; l++) begin
         tsh = tree >> ((1 << l) - 1 + p);
         d   = tsh[0];
         any = 1'b0;
         for (int w = 0; w < WAYS; w++)
            if (((w >> (WAY_W - 1 - l)) == ((p << 1) | int'(d))) && elig[w]) any = 1'b1;
         if (!any) d = ~d;
         p = (p << 1) | int'(d);
      end
      if (found)        victim = pick;
      else if (noalloc) victim = '0;
      else              victim = p[WAY_W-1:0];
   end
endmodule

// File: rtl/l1td_touch.sv
module l1td_touch #(
   parameter int WAYS = 8
) (
   input  logic [WAYS-2:0]          tree,
   input  logic [$clog2(WAYS)-1:0]  way,
   output logic [WAYS-2:0]          tree_nxt
);
   localparam int LVL = $clog2(WAYS);

   for (genvar l = 0; l < LVL; l++) begin : g_lvl
      for (genvar k = 0; k < (1 << l); k++) begin : g_node
         localparam int N = (1 << l) - 1 + k;
         if (l == 0) begin : g_root
            assign tree_nxt[N] = ~way[LVL-1];
         end else begin : g_inner
            assign tree_nxt[N] = (int'(way[LVL-1 -: l]) == k) ? ~way[LVL-1-l] : tree[N];
         end
      end
   end
endmodule

// File: rtl/l1_tag_dir.sv
module l1_tag_dir
   import l1td_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CACHE_BYTES = 32768,
   parameter int WAYS        = 8,
   parameter int LINE_BYTES  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     par_en,
   input  logic                     flush_go,
   output logic                     flush_busy,
   output logic                     op_ready,
   input  logic                     op_valid,
   input  logic [2:0]               op_code,
   input  logic [ADDR_W-1:0]        op_addr,
   input  logic [$clog2(WAYS)-1:0]  op_way,
   input  logic [1:0]               op_state,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic [$clog2(WAYS)-1:0]  rsp_way,
   output logic [1:0]               rsp_state,
   output logic                     rsp_perr,
   output logic [$clog2(WAYS)-1:0]  rsp_victim,
   output logic [1:0]               rsp_vic_state,
   output logic                     rsp_noalloc
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int SETS  = CACHE_BYTES / (WAYS * LINE_BYTES);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam int WAY_W = $clog2(WAYS);
   localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

   if (WAYS < 4 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 4");
   end
   if ((1 << OFF_W) != LINE_BYTES || (1 << IDX_W) != SETS) begin : g_bad_geom
      $error("line size and set count must be powers of two");
   end
   if (SETS * WAYS * LINE_BYTES != CACHE_BYTES || TAG_W < 1) begin : g_bad_size
      $error("cache size does not divide into sets, ways and lines");
   end

   logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
   logic [WAYS-1:0][1:0]       st_q   [SETS];
   logic [WAYS-1:0]            lk_q   [SETS];
   logic [WAYS-1:0]            par_q  [SETS];
   logic [WAYS-2:0]            tree_q [SETS];

   logic             flush_q;
   logic [IDX_W-1:0] fcnt;
   logic [IDX_W-1:0] rsp_set_q;

   dir_op_e          op;
   logic             acc;
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic             unused_off;
   logic [WAYS-1:0]  valid_v;
   logic             hit, perr, noalloc;
   logic [WAY_W-1:0] hit_way, victim, acc_way;
   logic [WAYS-2:0]  tree_nxt;

   assign op         = dir_op_e'(op_code);
   assign acc        = op_valid && !flush_q;
   assign idx        = op_addr[OFF_W +: IDX_W];
   assign tag        = op_addr[ADDR_W-1 -: TAG_W];
   assign unused_off = ^op_addr[OFF_W-1:0];
   assign acc_way    = (op == OP_FILL) ? op_way : hit_way;
   assign flush_busy = flush_q;
   assign op_ready   = !flush_q;

   for (genvar w = 0; w < WAYS; w++) begin : g_valid
      assign valid_v[w] = (st_q[idx][w] != ST_INV);
   end

   l1td_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .tag_in(tag), .way_tag(tag_q[idx]), .way_valid(valid_v),
      .way_par(par_q[idx]), .par_en(par_en),
      .hit(hit), .hit_way(hit_way), .perr(perr));

   l1td_victim #(.WAYS(WAYS)) u_victim (
      .valid(valid_v), .locked(lk_q[idx]), .tree(tree_q[idx]),
      .victim(victim), .noalloc(noalloc));

   l1td_touch #(.WAYS(WAYS)) u_touch (
      .tree(tree_q[idx]), .way(acc_way), .tree_nxt(tree_nxt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            st_q[s]   <= '0;
            lk_q[s]   <= '0;
            tree_q[s] <= '0;
         end
         flush_q <= 1'b0;
         fcnt    <= '0;
      end else begin
         if (flush_q) begin
            st_q[fcnt]   <= '0;
            lk_q[fcnt]   <= '0;
            tree_q[fcnt] <= '0;
            fcnt         <= fcnt + 1'b1;
            if (fcnt == LAST_SET) flush_q <= 1'b0;
         end else if (flush_go) begin
            flush_q <= 1'b1;
            fcnt    <= '0;
         end
         if (acc) begin
            case (op)
               OP_FILL: begin
                  st_q[idx][op_way] <= op_state;
                  lk_q[idx][op_way] <= 1'b0;
                  tree_q[idx]       <= tree_nxt;
               end
               OP_LOOK:   if (hit) tree_q[idx] <= tree_nxt;
               OP_INV: if (hit) begin
                  st_q[idx][hit_way] <= ST_INV;
                  lk_q[idx][hit_way] <= 1'b0;
               end
               OP_LOCK:   if (hit) lk_q[idx][hit_way] <= 1'b1;
               OP_UNLOCK: if (hit) lk_q[idx][hit_way] <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (acc && op == OP_FILL) begin
         tag_q[idx][op_way] <= tag;
         par_q[idx][op_way] <= par_en & (^tag);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_way       <= '0;
         rsp_state     <= ST_INV;
         rsp_perr      <= 1'b0;
         rsp_victim    <= '0;
         rsp_vic_state <= ST_INV;
         rsp_noalloc   <= 1'b0;
         rsp_set_q     <= '0;
      end else begin
         rsp_valid     <= acc && (op == OP_LOOK);
         rsp_hit       <= hit;
         rsp_way       <= hit ? hit_way : '0;
         rsp_state     <= hit ? st_q[idx][hit_way] : ST_INV;
         rsp_perr      <= perr;
         rsp_victim    <= victim;
         rsp_vic_state <= st_q[idx][victim];
         rsp_noalloc   <= noalloc;
         rsp_set_q     <= idx;
      end
   end

   // R6
   vic_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_noalloc |->
         !(lk_q[rsp_set_q][rsp_victim] && st_q[rsp_set_q][rsp_victim] != ST_INV));

   // R7
   noalloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_noalloc |-> (&lk_q[rsp_set_q]) && rsp_victim == '0);

   // R10
   perr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_perr |-> !rsp_hit);

   // R3
   hit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> rsp_state != ST_INV);

   // R11
   flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |=> !rsp_valid);

   // R11
   flush_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush_busy) |-> $past(fcnt) == LAST_SET);
endmodule

// File: tb/l1_tag_dir_bench.sv
`timescale 1ns/1ps
module l1_tag_dir_bench;
   localparam logic [2:0] LK = 3'd0, FL = 3'd1, IV = 3'd2, LC = 3'd3, UL = 3'd4;
   localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_E = 2'd2, S_M = 2'd3;

   typedef struct packed {
      logic [2:0]  op;
      logic [19:0] tag;
      logic [6:0]  set;
      logic [2:0]  way;
      logic [1:0]  st;
      logic        look;
      logic        hit;
      logic [2:0]  hway;
      logic [1:0]  hst;
      logic [2:0]  vic;
      logic        noal;
      logic [7:0]  req;
   } vec_t;

   function automatic vec_t V(logic [2:0] op, logic [19:0] tg, logic [6:0] s, logic [2:0] w,
                              logic [1:0] st, logic look, logic h, logic [2:0] hw,
                              logic [1:0] hs, logic [2:0] vc, logic na, logic [7:0] rq);
      vec_t r;
      r.op = op; r.tag = tg; r.set = s; r.way = w; r.st = st; r.look = look; r.hit = h;
      r.hway = hw; r.hst = hs; r.vic = vc; r.noal = na; r.req = rq;
      return r;
   endfunction

   localparam int NV = 32;
   localparam vec_t TBL [NV] = '{
      V(LK, 20'h100, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd0, 0, 8'd4),  // R4 empty set
      V(FL, 20'h100, 7'd3, 3'd0, S_E, 0, 0, 0, S_I, 0, 0, 8'd2),     // R2 fills give no response
      V(FL, 20'h101, 7'd3, 3'd1, S_M, 0, 0, 0, S_I, 0, 0, 8'd2),
      V(FL, 20'h102, 7'd3, 3'd2, S_S, 0, 0, 0, S_I, 0, 0, 8'd2),
      V(FL, 20'h103, 7'd3, 3'd3, S_E, 0, 0, 0, S_I, 0, 0, 8'd2),
      V(FL, 20'h104, 7'd3, 3'd4, S_E, 0, 0, 0, S_I, 0, 0, 8'd2),
      V(FL, 20'h105, 7'd3, 3'd5, S_E, 0, 0, 0, S_I, 0, 0, 8'd2),
      V(FL, 20'h106, 7'd3, 3'd6, S_E, 0, 0, 0, S_I, 0, 0, 8'd2),
      V(FL, 20'h107, 7'd3, 3'd7, S_E, 0, 0, 0, S_I, 0, 0, 8'd2),
      V(LK, 20'h100, 7'd3, 3'd0, S_I, 1, 1, 3'd0, S_E, 3'd0, 0, 8'd5), // R5 tree after fills 0..7
      V(LK, 20'h900, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd4, 0, 8'd5),    // R5 after hit on way 0
      V(LK, 20'h101, 7'd4, 3'd0, S_I, 1, 0, 0, S_I, 3'd0, 0, 8'd1),    // R1 other set misses
      V(LC, 20'h104, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LK, 20'h900, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd5, 0, 8'd6),    // R6 steer past locked 4
      V(LC, 20'h555, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),       // R8 absent tag
      V(LK, 20'h900, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd5, 0, 8'd8),    // R8 nothing changed
      V(LC, 20'h100, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LC, 20'h101, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LC, 20'h102, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LC, 20'h103, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LC, 20'h105, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LC, 20'h106, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LC, 20'h107, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LK, 20'h900, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd0, 1, 8'd7),    // R7 all locked
      V(UL, 20'h102, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd8),
      V(LK, 20'h900, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd2, 0, 8'd6),    // R6 root flips to left
      V(IV, 20'h106, 7'd3, 3'd0, S_I, 0, 0, 0, S_I, 0, 0, 8'd9),
      V(LK, 20'h900, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd6, 0, 8'd4),    // R4 invalid way first
      V(LK, 20'h106, 7'd3, 3'd0, S_I, 1, 0, 0, S_I, 3'd6, 0, 8'd9),    // R9 invalidated tag misses
      V(LK, 20'h101, 7'd3, 3'd0, S_I, 1, 1, 3'd1, S_M, 3'd6, 0, 8'd3), // R3 modified line
      V(LK, 20'h102, 7'd3, 3'd0, S_I, 1, 1, 3'd2, S_S, 3'd6, 0, 8'd3), // R3 shared line
      V(LK, 20'h104, 7'd3, 3'd0, S_I, 1, 1, 3'd4, S_E, 3'd6, 0, 8'd8)  // R8 locked line hits
   };

   logic        clk = 1'b0, rst_n = 1'b0, par_en = 1'b1, flush_go = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd0, op_way = 3'd0;
   logic [31:0] op_addr = '0;
   logic [1:0]  op_state = 2'd0;
   logic        flush_busy, op_ready, rsp_valid, rsp_hit, rsp_perr, rsp_noalloc;
   logic [2:0]  rsp_way, rsp_victim;
   logic [1:0]  rsp_state, rsp_vic_state;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   l1_tag_dir u_l1_tag_dir (
      .clk(clk), .rst_n(rst_n), .par_en(par_en), .flush_go(flush_go),
      .flush_busy(flush_busy), .op_ready(op_ready), .op_valid(op_valid),
      .op_code(op_code), .op_addr(op_addr), .op_way(op_way), .op_state(op_state),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
      .rsp_state(rsp_state), .rsp_perr(rsp_perr), .rsp_victim(rsp_victim),
      .rsp_vic_state(rsp_vic_state), .rsp_noalloc(rsp_noalloc));

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic drive(logic [2:0] op, logic [19:0] tg, logic [6:0] s, logic [2:0] w,
                        logic [1:0] st);
      op_valid = 1'b1; op_code = op; op_addr = {tg, s, 5'h00}; op_way = w; op_state = st;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R11 watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 rsp_valid after reset", 32'(rsp_valid), 0);
      check("R12 flush_busy after reset", 32'(flush_busy), 0);
      check("R12 op_ready after reset", 32'(op_ready), 1);
      drive(LK, 20'h0ABC, 7'd100, 0, S_I);
      check("R12 empty set hit", 32'(rsp_hit), 0);
      check("R12 empty set victim", 32'(rsp_victim), 0);
      check("R12 empty set noalloc", 32'(rsp_noalloc), 0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string tagtxt;
         v = TBL[i];
         tagtxt = $sformatf("R%0d vec%0d", v.req, i);
         drive(v.op, v.tag, v.set, v.way, v.st);
         check({tagtxt, " rsp_valid"}, 32'(rsp_valid), 32'(v.look));
         if (v.look) begin
            check({tagtxt, " hit"}, 32'(rsp_hit), 32'(v.hit));
            check({tagtxt, " way"}, 32'(rsp_way), 32'(v.hway));
            check({tagtxt, " state"}, 32'(rsp_state), 32'(v.hst));
            check({tagtxt, " victim"}, 32'(rsp_victim), 32'(v.vic));
            check({tagtxt, " noalloc"}, 32'(rsp_noalloc), 32'(v.noal));
         end
      end

      // R10 parity behaviour in set 9
      par_en = 1'b0;
      drive(FL, 20'h00001, 7'd9, 3'd0, S_S);
      drive(FL, 20'h00003, 7'd9, 3'd1, S_E);
      par_en = 1'b1;
      drive(FL, 20'h00007, 7'd9, 3'd2, S_M);
      drive(LK, 20'h00001, 7'd9, 0, S_I);
      check("R10 odd tag stored without parity: perr", 32'(rsp_perr), 1);
      check("R10 odd tag stored without parity: hit", 32'(rsp_hit), 0);
      drive(LK, 20'h00003, 7'd9, 0, S_I);
      check("R10 even tag: hit", 32'(rsp_hit), 1);
      check("R10 even tag: perr", 32'(rsp_perr), 0);
      drive(LK, 20'h00007, 7'd9, 0, S_I);
      check("R10 generated parity: way", 32'(rsp_way), 2);
      check("R10 generated parity: state", 32'(rsp_state), 32'(S_M));
      par_en = 1'b0;
      drive(LK, 20'h00001, 7'd9, 0, S_I);
      check("R10 check disabled: hit", 32'(rsp_hit), 1);
      check("R10 check disabled: state", 32'(rsp_state), 32'(S_S));
      check("R10 check disabled: perr", 32'(rsp_perr), 0);
      par_en = 1'b1;

      // R11 flush
      flush_go = 1'b1;
      @(negedge clk);
      flush_go = 1'b0;
      begin
         int n;
         n = 0;
         while (flush_busy && n < 1000) begin
            n++;
            op_valid = (n == 3) || (n == 10);
            op_code  = (n == 3) ? LK : FL;
            op_addr  = (n == 3) ? {20'h101, 7'd3, 5'h00} : {20'h222, 7'd0, 5'h00};
            op_way   = 3'd0;
            op_state = S_E;
            if (n == 2) check("R11 op_ready low during flush", 32'(op_ready), 0);
            @(negedge clk);
            op_valid = 1'b0;
            if (n == 3) check("R11 lookup dropped during flush", 32'(rsp_valid), 0);
         end
         check("R11 flush length", 32'(n), 128);
      end
      check("R11 op_ready after flush", 32'(op_ready), 1);
      drive(LK, 20'h222, 7'd0, 0, S_I);
      check("R11 fill during flush dropped", 32'(rsp_hit), 0);
      drive(LK, 20'h101, 7'd3, 0, S_I);
      check("R11 line cleared", 32'(rsp_hit), 0);
      check("R11 locks cleared: noalloc", 32'(rsp_noalloc), 0);
      check("R11 locks cleared: victim", 32'(rsp_victim), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule